// File: doc/BRIEF.md
# Banked register file decoder

This block is the data memory of a small 8-bit controller core. The core sees two banks of 128 locations each. The low twelve offsets of a bank hold control registers and the upper offsets hold general-purpose bytes. A 7-bit address from the instruction word and a bank bit taken from the status register together form an 8-bit file address. The block resolves that address to one of four things: a shared RAM byte, a register common to both banks, a register private to one bank, or an empty location.

Indirect access uses the 8-bit pointer register as the whole address. An access is indirect when the core raises the indirect flag or names offset zero. Offset zero has no storage of its own. When the pointer itself aims at offset zero of either bank, the access reads zero and writes nothing. Both the status and pointer registers are ordinary locations in the file, so the core changes the bank and the pointer by writing to them.

Top module: `banked_regfile`

## Requirements
- R1: A direct access uses the address {status[5], addr[6:0]}, so status bit 5 selects the bank. A write to the status register at offset 03h changes the bank from the next access on.
- R2: Offsets 0Ch–4Fh hold 68 general-purpose bytes. Full addresses 8Ch–CFh reach the same bytes as 0Ch–4Fh.
- R3: Offset 07h and offsets 50h–7Fh are empty in both banks. They read as 00h, and writes to them change nothing.
- R4: Offsets 02h, 03h (status), 04h (pointer), 0Ah and 0Bh are each one physical register that both banks share.
- R5: Offsets 01h, 05h, 06h, 08h and 09h are separate registers in bank 0 and bank 1.
- R6: When the indirect flag is high, or when the direct address is 00h, the access goes to the full 8-bit address held in the pointer register (offset 04h).
- R7: An indirect access whose pointer has bits [6:0] equal to zero (00h or 80h) reads 00h and writes nothing.
- R8: A write takes effect at the rising clock edge. Reads are combinational, so a location being written shows its old value until that edge.
- R9: Reset clears every control register, including status and pointer, to 00h. The general-purpose bytes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Direct address field from the instruction |
| ind_sel | input | 1 | Marks the access as indirect through the pointer |
| wr_en | input | 1 | Write enable |
| wr_data | input | 8 | Data to write |
| rd_data | output | 8 | Combinational read data |

## Verification
The bench builds the block with its default parameters: a 68-byte general region starting at offset 0Ch and twelve control offsets per bank. With that size it can walk every general byte from both banks, every empty offset, and all 256 pointer values. The pointer sweep reaches the corner cases: the pointer aiming at itself or at status, the null targets 00h and 80h, and implicit indirection through offset 00h. In each case the bench predicts the result from a model of the mapping written from the requirements.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW        = 8,
  parameter int GPR_FIRST = 12,
  parameter int GPR_LAST  = 79,
  parameter int STAT_OFF  = 3,
  parameter int PTR_OFF   = 4,
  parameter int BANK_BIT  = 5,
  parameter logic [15:0] SHARED_MASK = 16'h0C1C,
  parameter logic [15:0] HOLE_MASK   = 16'h0081
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dir_addr,
  input  logic          ind_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int GPR_DEPTH = GPR_LAST - GPR_FIRST + 1;
  localparam logic [6:0] G_LO = 7'(GPR_FIRST);
  localparam logic [6:0] G_HI = 7'(GPR_LAST);
  localparam int SFR_SLOTS = 32;

  logic [DW-1:0] sfr [SFR_SLOTS];
  logic [DW-1:0] gpr [GPR_DEPTH];

  logic [DW-1:0] stat, ptr;
  assign stat = sfr[STAT_OFF];
  assign ptr  = sfr[PTR_OFF];

  logic       ind_acc, bk, null_hit, in_sfr, is_shared, is_gpr, is_reg, hole_hit;
  logic [7:0] eff;
  logic [6:0] off, gidx;
  logic [4:0] sidx;

  assign ind_acc   = ind_sel || (dir_addr == 7'd0);
  assign eff       = ind_acc ? ptr[7:0] : {stat[BANK_BIT], dir_addr};
  assign off       = eff[6:0];
  assign bk        = eff[7];
  assign null_hit  = ind_acc && (off == 7'd0);
  assign in_sfr    = off < G_LO;
  assign is_shared = in_sfr && SHARED_MASK[off[3:0]];
  assign is_gpr    = (off >= G_LO) && (off <= G_HI);
  assign is_reg    = in_sfr && !HOLE_MASK[off[3:0]];
  assign hole_hit  = !null_hit && !is_gpr && !is_reg;
  assign gidx      = off - G_LO;
  assign sidx      = {bk & ~is_shared, off[3:0]};

  always_comb begin
    rd_data = '0;
    if (!null_hit) begin
      if (is_gpr)      rd_data = gpr[gidx];
      else if (is_reg) rd_data = sfr[sidx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SFR_SLOTS; i++) sfr[i] <= '0;
    end else if (wr_en && !null_hit && is_reg) begin
      sfr[sidx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !null_hit && is_gpr) gpr[gidx] <= wr_data;
  end

  AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && null_hit) |=> ($stable(stat) && $stable(ptr))) else $error("null write"); // R7
  AST_NULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    null_hit |-> (rd_data == '0)) else $error("null read"); // R7
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hole_hit |-> (rd_data == '0)) else $error("hole read"); // R3
  AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hole_hit) |=> ($stable(stat) && $stable(ptr))) else $error("hole write"); // R3
  AST_BANK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !null_hit && is_reg && off == 7'(STAT_OFF)) |=> (stat[BANK_BIT] == $past(wr_data[BANK_BIT])))
    else $error("bank bit"); // R1
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !null_hit && is_reg && off == 7'(PTR_OFF)) |=> (ptr == $past(wr_data)))
    else $error("pointer load"); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (stat == '0 && ptr == '0)) else $error("reset"); // R9
endmodule

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic clk = 1'b0, rst_n = 1'b0, ind_sel = 1'b0, wr_en = 1'b0;
  logic [6:0] dir_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;
  logic [7:0] m [256];
  bit k [256];

  always #10 clk = ~clk;

  banked_regfile u0 (.clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .ind_sel(ind_sel),
                     .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  function automatic int tgt(input logic [7:0] a, input bit ind);
    logic [6:0] o = a[6:0];
    if (ind && o == 0) return -1;
    if (o == 0 || o == 7 || o > 7'h4F) return -1;
    if (o >= 7'h0C) return int'(o);
    if (o == 2 || o == 3 || o == 4 || o == 10 || o == 11) return int'(o);
    return int'(a);
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", r, act, exp);
    end
  endtask

  task automatic op(string r, bit ind, logic [6:0] d, bit we, logic [7:0] wd);
    bit i2 = ind || (d == 0);
    logic [7:0] ea = i2 ? m[4] : {m[3][5], d};
    int t = tgt(ea, i2);
    @(negedge clk);
    ind_sel = ind; dir_addr = d; wr_en = we; wr_data = wd;
    #2;
    if (t < 0) chk(r, rd_data, 8'h00);
    else if (k[t]) chk(we ? {r, " R8 old value before edge"} : r, rd_data, m[t]);
    if (we) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (t >= 0) begin m[t] = wd; k[t] = 1'b1; end
    end
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin m[i] = '0; k[i] = 1'b0; end
    for (int i = 1; i < 12; i++) if (i != 7) begin k[i] = 1'b1; k[i + 128] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state of control registers in both banks
    for (int i = 1; i < 12; i++) op("R9 reset clear", 1'b0, 7'(i), 1'b0, 8'h00);
    op("R1 select bank 1", 1'b0, 7'd3, 1'b1, 8'h20);
    for (int i = 1; i < 12; i++) op("R9 reset clear bank 1", 1'b0, 7'(i), 1'b0, 8'h00);
    op("R1 select bank 0", 1'b0, 7'd3, 1'b1, 8'h00);
    // R2: fill from bank 0, read from bank 1, then the reverse
    for (int i = 12; i < 80; i++) op("R2 fill", 1'b0, 7'(i), 1'b1, 8'(i * 3 + 1));
    op("R1 select bank 1", 1'b0, 7'd3, 1'b1, 8'h20);
    for (int i = 12; i < 80; i++) op("R2 mirror read", 1'b0, 7'(i), 1'b0, 8'h00);
    for (int i = 12; i < 80; i++) op("R2 fill bank 1", 1'b0, 7'(i), 1'b1, 8'(~(i * 5)));
    op("R1 select bank 0", 1'b0, 7'd3, 1'b1, 8'h00);
    for (int i = 12; i < 80; i++) op("R2 mirror read back", 1'b0, 7'(i), 1'b0, 8'h00);
    // R3: empty locations in both banks
    for (int b = 0; b < 2; b++) begin
      op("R1 bank switch", 1'b0, 7'd3, 1'b1, 8'(b << 5));
      op("R3 write hole 07", 1'b0, 7'd7, 1'b1, 8'hFF);
      op("R3 read hole 07", 1'b0, 7'd7, 1'b0, 8'h00);
      for (int i = 80; i < 128; i++) begin
        op("R3 write hole", 1'b0, 7'(i), 1'b1, 8'hFF);
        op("R3 read hole", 1'b0, 7'(i), 1'b0, 8'h00);
      end
      for (int i = 12; i < 80; i++) op("R3 general bytes untouched", 1'b0, 7'(i), 1'b0, 8'h00);
    end
    // R4 and R5: shared versus bank-private control registers
    for (int b = 0; b < 2; b++) begin
      op("R1 bank switch", 1'b0, 7'd3, 1'b1, 8'(b << 5));
      for (int i = 1; i < 12; i++)
        if (i != 3 && i != 4 && i != 7) op("R5 R4 write", 1'b0, 7'(i), 1'b1, 8'(i * 17 + b * 64 + 1));
    end
    for (int b = 0; b < 2; b++) begin
      op("R1 bank switch", 1'b0, 7'd3, 1'b1, 8'(b << 5));
      for (int i = 1; i < 12; i++) op("R5 R4 cross-bank read", 1'b0, 7'(i), 1'b0, 8'h00);
    end
    op("R4 status seen in bank 1", 1'b0, 7'd3, 1'b0, 8'h00);
    // R6 and R7: every pointer value
    for (int p = 0; p < 256; p++) begin
      op("R6 load pointer", 1'b0, 7'd4, 1'b1, 8'(p));
      if (p[6:0] == 0) begin
        op("R7 null write", 1'b1, 7'h15, 1'b1, 8'h77);
        op("R7 null read", 1'b1, 7'h15, 1'b0, 8'h00);
        op("R7 pointer kept", 1'b0, 7'd4, 1'b0, 8'h00);
        op("R7 status kept", 1'b0, 7'd3, 1'b0, 8'h00);
      end else if (p[6:0] != 3 && p[6:0] != 4) begin
        op("R6 indirect write", 1'b1, 7'h2A, 1'b1, 8'(p ^ 8'hA5));
        op("R6 indirect read", 1'b1, 7'h2A, 1'b0, 8'h00);
        op("R6 implicit indirect read", 1'b0, 7'd0, 1'b0, 8'h00);
      end else begin
        op("R6 indirect read of pointer or status", 1'b1, 7'h01, 1'b0, 8'h00);
      end
    end
    op("R6 implicit indirect write", 1'b0, 7'd0, 1'b1, 8'h3C);
    op("R6 implicit indirect read back", 1'b1, 7'd0, 1'b0, 8'h00);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule